// File: doc/BRIEF.md
# Receive Object Status Flag Manager

This block holds the status flags of every receive slot in a CAN message handler. Each slot has four flags: fresh data, overrun, interrupt pending and remote-request pending. The flags change on four kinds of event. The acceptance selector raises a store strobe when it writes a frame into a slot. The CPU sends read-transfer commands through an interface command port. The CPU also sends flag writes that clear the overrun flag or arm a remote request. The transmit scheduler acknowledges remote frames it has sent.

The flag vectors go to the selector and to the CPU side. The global interrupt line is the OR of all interrupt-pending flags. A read-transfer command returns, one cycle later, a snapshot of the slot's flags as they stood before the command changed them.

The remote-request output always shows the lowest-numbered slot that has a pending request. If a data frame for that slot is stored before the remote frame leaves, the request is withdrawn by itself. A per-slot enable input decides whether a slot takes part at all. A per-slot interrupt enable decides whether a store raises that slot's interrupt.

Top module: `can_objstat_mgr`

## Requirements
- R1: A store strobe to an enabled slot sets that slot's fresh-data flag in the next cycle.
- R2: A store to an enabled slot whose fresh-data flag is already set sets that slot's overrun flag.
- R3: The overrun flag is cleared only by a CPU write with the clear-overrun bit. If that write meets a store that overruns the same slot in the same cycle, the flag stays set.
- R4: A read-transfer command with mask value 0x7F clears both fresh-data and interrupt-pending for the named slot. Mask bit 2 alone clears only fresh-data. Mask bit 3 alone clears only interrupt-pending. No other mask bit changes any flag.
- R5: A store sets interrupt-pending only when that slot's interrupt enable is high. The `irq` output is high exactly when any interrupt-pending flag is set.
- R6: When a store and a read-transfer clear hit the same slot in the same cycle, the store wins: fresh-data stays set, and interrupt-pending stays set if the interrupt enable is high.
- R7: A CPU write with the arm-request bit sets the remote-request flag of an enabled slot. `tx_req_vld` is high when any request is pending, and `tx_req_idx` names the lowest-numbered pending slot.
- R8: A store into a slot clears its remote-request flag, including in a cycle where the request is being armed.
- R9: A transmit-done acknowledge clears the remote-request flag of the named slot only.
- R10: Stores and arm-request writes aimed at a disabled slot change no flag.
- R11: One cycle after a read-transfer command, `rd_snap_vld` pulses. The snapshot outputs then show the named slot's fresh-data, overrun and interrupt-pending flags as they stood before the command.
- R12: After reset, every flag is clear, and `irq`, `tx_req_vld` and `rd_snap_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | NUM_OBJ | Per-slot enable |
| slot_rxie | input | NUM_OBJ | Per-slot receive interrupt enable |
| st_vld | input | 1 | Store strobe from the acceptance selector |
| st_idx | input | IDX_W | Slot written by the store |
| rd_vld | input | 1 | Read-transfer command |
| rd_idx | input | IDX_W | Slot named by the read-transfer |
| rd_mask | input | 8 | Command mask (bit 2 clears fresh-data, bit 3 clears interrupt) |
| wr_vld | input | 1 | CPU flag write |
| wr_idx | input | IDX_W | Slot named by the flag write |
| wr_clr_ovr | input | 1 | Clear the overrun flag |
| wr_arm_rtr | input | 1 | Arm a remote request |
| txd_vld | input | 1 | Transmit-done acknowledge |
| txd_idx | input | IDX_W | Slot whose remote frame was sent |
| fresh | output | NUM_OBJ | Fresh-data flags |
| ovr | output | NUM_OBJ | Overrun flags |
| ipend | output | NUM_OBJ | Interrupt-pending flags |
| rtr_pend | output | NUM_OBJ | Remote-request flags |
| irq | output | 1 | OR of all interrupt-pending flags |
| tx_req_vld | output | 1 | A remote request is pending |
| tx_req_idx | output | IDX_W | Lowest-numbered pending slot |
| rd_snap_vld | output | 1 | Snapshot valid pulse |
| rd_snap_fresh | output | 1 | Snapshot fresh-data flag |
| rd_snap_ovr | output | 1 | Snapshot overrun flag |
| rd_snap_ipend | output | 1 | Snapshot interrupt-pending flag |

## Verification
The bench aims at same-cycle collisions on one slot: a store against a read-transfer clear, a store against a clear-overrun write, and a store against an arm-request. A design that let the clear win would lose fresh data or overrun history. A design that let the arm win would send a remote frame for data it already holds.

It also drives partial command masks and slots that are disabled or have their interrupt masked. It checks the read snapshot against the flag values from before the command. A design that sampled after the update would report fresh-data as already cleared.

Randomized traffic on few slots keeps requests pending on several slots at once. A wrong priority encoder would then show up as a wrong `tx_req_idx`.

// File: rtl/can_objstat_pkg.sv
package can_objstat_pkg;

  localparam int CMD_W        = 8;
  localparam int ACK_FRESH_B  = 2;
  localparam int ACK_IPEND_B  = 3;
  localparam logic [CMD_W-1:0] CMD_FULL_READ = 8'h7F;

  typedef struct packed {
    logic fresh;
    logic ovr;
    logic ipend;
    logic rtr;
  } slot_flags_t;

  // Next-state rule of one slot; the event inputs are already qualified.
  function automatic slot_flags_t flag_next(
    input slot_flags_t cur,
    input logic        stored,
    input logic        rxie,
    input logic        ack_fresh,
    input logic        ack_ipend,
    input logic        clr_ovr,
    input logic        arm_rtr,
    input logic        tx_done
  );
    slot_flags_t n;
    n.fresh = stored | (cur.fresh & ~ack_fresh);
    n.ovr   = (stored & cur.fresh) | (cur.ovr & ~clr_ovr);
    n.ipend = (stored & rxie) | (cur.ipend & ~ack_ipend);
    n.rtr   = ~stored & ((cur.rtr & ~tx_done) | arm_rtr);
    return n;
  endfunction

endpackage

// File: rtl/can_objstat_slot.sv
module can_objstat_slot
  import can_objstat_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int SLOT    = 0,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rxie,
  input  logic             st_vld,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             rd_vld,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [CMD_W-1:0] rd_mask,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_clr_ovr,
  input  logic             wr_arm_rtr,
  input  logic             txd_vld,
  input  logic [IDX_W-1:0] txd_idx,
  output slot_flags_t      flags
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT);

  // Named event wires, shared by the update and the assertions.
  logic st_hit, st_miss_dis, rd_hit, wr_hit, txd_hit;
  logic ack_fresh, ack_ipend, clr_ovr, arm_rtr;
  slot_flags_t flags_d;

  assign st_hit      = st_vld && (st_idx == MY_IDX) && en;
  assign st_miss_dis = st_vld && (st_idx == MY_IDX) && !en;
  assign rd_hit      = rd_vld && (rd_idx == MY_IDX);
  assign wr_hit      = wr_vld && (wr_idx == MY_IDX);
  assign txd_hit     = txd_vld && (txd_idx == MY_IDX);
  assign ack_fresh   = rd_hit && rd_mask[ACK_FRESH_B];
  assign ack_ipend   = rd_hit && rd_mask[ACK_IPEND_B];
  assign clr_ovr     = wr_hit && wr_clr_ovr;
  assign arm_rtr     = wr_hit && wr_arm_rtr && en;

  always_comb begin
    flags_d = flag_next(flags, st_hit, rxie, ack_fresh, ack_ipend,
                        clr_ovr, arm_rtr, txd_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  // R1
  store_sets_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |=> flags.fresh);
  // R2
  overrun_on_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && flags.fresh) |=> flags.ovr);
  // R3
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.ovr && !clr_ovr) |=> flags.ovr);
  // R8
  store_cancels_rtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |=> !flags.rtr);
  // R10
  disabled_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_miss_dis && !flags.fresh) |=> !flags.fresh);
  // R5
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !rxie && !flags.ipend) |=> !flags.ipend);

endmodule

// File: rtl/can_objstat_txsel.sv
module can_objstat_txsel #(
  parameter int NUM_OBJ = 8,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] req,
  output logic               vld,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R7
  sel_points_at_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> req[idx]);
  // R7
  sel_valid_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> vld);

endmodule

// File: rtl/can_objstat_snap.sv
module can_objstat_snap
  import can_objstat_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_vld,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_OBJ-1:0] fresh,
  input  logic [NUM_OBJ-1:0] ovr,
  input  logic [NUM_OBJ-1:0] ipend,
  output logic               snap_vld,
  output logic               snap_fresh,
  output logic               snap_ovr,
  output logic               snap_ipend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_vld   <= 1'b0;
      snap_fresh <= 1'b0;
      snap_ovr   <= 1'b0;
      snap_ipend <= 1'b0;
    end else begin
      snap_vld <= rd_vld;
      if (rd_vld) begin
        snap_fresh <= fresh[rd_idx];
        snap_ovr   <= ovr[rd_idx];
        snap_ipend <= ipend[rd_idx];
      end
    end
  end

  // R11
  snap_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |=> snap_vld);
  // R11
  snap_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |=> !snap_vld);

endmodule

// File: rtl/can_objstat_mgr.sv
module can_objstat_mgr
  import can_objstat_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] slot_en,
  input  logic [NUM_OBJ-1:0] slot_rxie,
  input  logic               st_vld,
  input  logic [IDX_W-1:0]   st_idx,
  input  logic               rd_vld,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [7:0]         rd_mask,
  input  logic               wr_vld,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_clr_ovr,
  input  logic               wr_arm_rtr,
  input  logic               txd_vld,
  input  logic [IDX_W-1:0]   txd_idx,
  output logic [NUM_OBJ-1:0] fresh,
  output logic [NUM_OBJ-1:0] ovr,
  output logic [NUM_OBJ-1:0] ipend,
  output logic [NUM_OBJ-1:0] rtr_pend,
  output logic               irq,
  output logic               tx_req_vld,
  output logic [IDX_W-1:0]   tx_req_idx,
  output logic               rd_snap_vld,
  output logic               rd_snap_fresh,
  output logic               rd_snap_ovr,
  output logic               rd_snap_ipend
);

  slot_flags_t slot_q [NUM_OBJ];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_slot
    can_objstat_slot #(.NUM_OBJ(NUM_OBJ), .SLOT(g)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (slot_en[g]),
      .rxie       (slot_rxie[g]),
      .st_vld     (st_vld),
      .st_idx     (st_idx),
      .rd_vld     (rd_vld),
      .rd_idx     (rd_idx),
      .rd_mask    (rd_mask),
      .wr_vld     (wr_vld),
      .wr_idx     (wr_idx),
      .wr_clr_ovr (wr_clr_ovr),
      .wr_arm_rtr (wr_arm_rtr),
      .txd_vld    (txd_vld),
      .txd_idx    (txd_idx),
      .flags      (slot_q[g])
    );
    assign fresh[g]    = slot_q[g].fresh;
    assign ovr[g]      = slot_q[g].ovr;
    assign ipend[g]    = slot_q[g].ipend;
    assign rtr_pend[g] = slot_q[g].rtr;
  end

  assign irq = |ipend;

  can_objstat_txsel #(.NUM_OBJ(NUM_OBJ)) u_txsel (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rtr_pend),
    .vld   (tx_req_vld),
    .idx   (tx_req_idx)
  );

  can_objstat_snap #(.NUM_OBJ(NUM_OBJ)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_vld     (rd_vld),
    .rd_idx     (rd_idx),
    .fresh      (fresh),
    .ovr        (ovr),
    .ipend      (ipend),
    .snap_vld   (rd_snap_vld),
    .snap_fresh (rd_snap_fresh),
    .snap_ovr   (rd_snap_ovr),
    .snap_ipend (rd_snap_ipend)
  );

  // R9
  txdone_clears_rtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_vld && !(wr_vld && wr_arm_rtr && wr_idx == txd_idx)) |=> !rtr_pend[$past(txd_idx)]);
  // R4
  full_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_mask == CMD_FULL_READ && !(st_vld && st_idx == rd_idx))
      |=> (!fresh[$past(rd_idx)] && !ipend[$past(rd_idx)]));

endmodule

// File: tb/can_objstat_mgr_bench.sv
module can_objstat_mgr_bench;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] slot_en = '1, slot_rxie = '1;
  logic st_vld = 0, rd_vld = 0, wr_vld = 0, txd_vld = 0;
  logic [IW-1:0] st_idx = '0, rd_idx = '0, wr_idx = '0, txd_idx = '0;
  logic [7:0] rd_mask = '0;
  logic wr_clr_ovr = 0, wr_arm_rtr = 0;
  logic [N-1:0] fresh, ovr, ipend, rtr_pend;
  logic irq, tx_req_vld, rd_snap_vld, rd_snap_fresh, rd_snap_ovr, rd_snap_ipend;
  logic [IW-1:0] tx_req_idx;

  always #(CLK_P/2) clk = ~clk;

  can_objstat_mgr #(.NUM_OBJ(N)) u_can_objstat_mgr (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_rxie(slot_rxie),
    .st_vld(st_vld), .st_idx(st_idx), .rd_vld(rd_vld), .rd_idx(rd_idx),
    .rd_mask(rd_mask), .wr_vld(wr_vld), .wr_idx(wr_idx),
    .wr_clr_ovr(wr_clr_ovr), .wr_arm_rtr(wr_arm_rtr),
    .txd_vld(txd_vld), .txd_idx(txd_idx),
    .fresh(fresh), .ovr(ovr), .ipend(ipend), .rtr_pend(rtr_pend), .irq(irq),
    .tx_req_vld(tx_req_vld), .tx_req_idx(tx_req_idx),
    .rd_snap_vld(rd_snap_vld), .rd_snap_fresh(rd_snap_fresh),
    .rd_snap_ovr(rd_snap_ovr), .rd_snap_ipend(rd_snap_ipend)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference model state
  logic [N-1:0] m_fr = '0, m_ov = '0, m_ip = '0, m_rt = '0;
  logic m_sv = 0, m_sf = 0, m_so = 0, m_si = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  // Advance the model using the inputs currently driven.
  task automatic model_step();
    logic [N-1:0] fr, ov, ip, rt;
    fr = m_fr; ov = m_ov; ip = m_ip; rt = m_rt;
    m_sv = rd_vld;
    if (rd_vld) begin
      m_sf = m_fr[rd_idx]; m_so = m_ov[rd_idx]; m_si = m_ip[rd_idx];
    end
    for (int i = 0; i < N; i++) begin
      bit st;
      st = st_vld && int'(st_idx) == i && slot_en[i];
      if (rd_vld && int'(rd_idx) == i) begin
        if (rd_mask[2]) fr[i] = 0;
        if (rd_mask[3]) ip[i] = 0;
      end
      if (wr_vld && int'(wr_idx) == i) begin
        if (wr_clr_ovr) ov[i] = 0;
      end
      if (txd_vld && int'(txd_idx) == i) rt[i] = 0;
      if (wr_vld && int'(wr_idx) == i && wr_arm_rtr && slot_en[i]) rt[i] = 1;
      if (st) begin
        if (m_fr[i]) ov[i] = 1;
        fr[i] = 1;
        if (slot_rxie[i]) ip[i] = 1;
        rt[i] = 0;
      end
    end
    m_fr = fr; m_ov = ov; m_ip = ip; m_rt = rt;
  endtask

  task automatic compare_all();
    chk("R1 fresh", 32'(fresh), 32'(m_fr));
    chk("R2 ovr", 32'(ovr), 32'(m_ov));
    chk("R5 ipend", 32'(ipend), 32'(m_ip));
    chk("R5 irq", 32'(irq), 32'(|m_ip));
    chk("R8 rtr", 32'(rtr_pend), 32'(m_rt));
    chk("R7 txvld", 32'(tx_req_vld), 32'(|m_rt));
    if (|m_rt) chk("R7 txidx", 32'(tx_req_idx), 32'(lowest(m_rt)));
    chk("R11 snapvld", 32'(rd_snap_vld), 32'(m_sv));
    if (m_sv) chk("R11 snap", {29'd0, rd_snap_fresh, rd_snap_ovr, rd_snap_ipend},
                  {29'd0, m_sf, m_so, m_si});
  endtask

  task automatic idle();
    st_vld = 0; rd_vld = 0; wr_vld = 0; txd_vld = 0;
    rd_mask = '0; wr_clr_ovr = 0; wr_arm_rtr = 0;
  endtask

  // inputs driven at negedge; one clock; compare at next negedge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic do_store(input int i);
    st_vld = 1; st_idx = IW'(i);
  endtask
  task automatic do_read(input int i, input logic [7:0] m);
    rd_vld = 1; rd_idx = IW'(i); rd_mask = m;
  endtask
  task automatic do_wr(input int i, input logic c, input logic a);
    wr_vld = 1; wr_idx = IW'(i); wr_clr_ovr = c; wr_arm_rtr = a;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 flags", 32'({fresh, ovr, ipend, rtr_pend}), 32'd0);
    chk("R12 outs", {29'd0, irq, tx_req_vld, rd_snap_vld}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1/R2: two stores into slot 2 -> overrun
    do_store(2); tick();
    chk("R1 fresh2", 32'(fresh[2]), 32'd1);
    do_store(2); tick();
    chk("R2 ovr2", 32'(ovr[2]), 32'd1);
    // R4 full read clears fresh and ipend, not overrun; R11 snapshot
    do_read(2, 8'h7F); tick();
    chk("R4 fullread", {29'd0, fresh[2], ipend[2], ovr[2]}, {29'd0, 1'b0, 1'b0, 1'b1});
    chk("R11 snapfresh", 32'(rd_snap_fresh), 32'd1);
    // R3 overrun survives stores and reads, clears on write
    do_read(2, 8'h7F); tick();
    chk("R3 sticky", 32'(ovr[2]), 32'd1);
    do_wr(2, 1, 0); tick();
    chk("R3 cleared", 32'(ovr[2]), 32'd0);
    // R3 clear vs overrunning store in same cycle: store wins
    do_store(2); tick();
    do_store(2); do_wr(2, 1, 0); tick();
    chk("R3 storewins", 32'(ovr[2]), 32'd1);
    // R4 partial masks
    do_store(5); tick();
    do_read(5, 8'h04); tick();
    chk("R4 mask2", {30'd0, fresh[5], ipend[5]}, {30'd0, 1'b0, 1'b1});
    do_store(5); tick();
    do_read(5, 8'h08); tick();
    chk("R4 mask3", {30'd0, fresh[5], ipend[5]}, {30'd0, 1'b1, 1'b0});
    do_read(5, 8'hF3); tick();
    chk("R4 otherbits", 32'(fresh[5]), 32'd1);
    // R6 store + full read same slot
    do_store(6); do_read(6, 8'h7F); tick();
    chk("R6 storewins", {30'd0, fresh[6], ipend[6]}, {30'd0, 1'b1, 1'b1});
    // R5 masked interrupt
    slot_rxie[1] = 0; do_store(1); tick();
    chk("R5 masked", 32'(ipend[1]), 32'd0);
    slot_rxie[1] = 1;
    // R7 arm two requests, lowest first; R9 done
    do_wr(4, 0, 1); tick();
    do_wr(3, 0, 1); tick();
    chk("R7 lowest", 32'(tx_req_idx), 32'd3);
    txd_vld = 1; txd_idx = 3; tick();
    chk("R9 done", {30'd0, rtr_pend[3], rtr_pend[4]}, {30'd0, 1'b0, 1'b1});
    // R8 store cancels pending request; and same-cycle arm
    do_store(4); tick();
    chk("R8 cancel", 32'(tx_req_vld), 32'd0);
    do_store(0); do_wr(0, 0, 1); tick();
    chk("R8 armcollide", 32'(rtr_pend[0]), 32'd0);
    // R10 disabled slot ignores store and arm
    slot_en[7] = 0; do_store(7); tick();
    do_wr(7, 0, 1); tick();
    chk("R10 disabled", {30'd0, fresh[7], rtr_pend[7]}, 32'd0);
    slot_en[7] = 1;

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      if ((k % 500) == 0) begin
        slot_en = N'($urandom) | N'($urandom);
        slot_rxie = N'($urandom) | N'($urandom);
      end
      if ($urandom_range(0, 2) == 0) do_store(int'($urandom_range(0, N-1)));
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] mk;
        case ($urandom_range(0, 3))
          0: mk = 8'h7F;
          1: mk = 8'h04;
          2: mk = 8'h08;
          default: mk = 8'($urandom);
        endcase
        do_read(int'($urandom_range(0, N-1)), mk);
      end
      if ($urandom_range(0, 3) == 0)
        do_wr(int'($urandom_range(0, N-1)), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        txd_vld = 1;
        txd_idx = (|m_rt && $urandom_range(0, 1) == 1) ? IW'(lowest(m_rt))
                                                       : IW'($urandom_range(0, N-1));
      end
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule